// File: doc/BRIEF.md
# Bus-Matching Read-Side Width Converter

This block sits between the read side of a 36-bit FIFO and a port whose width can be set to the full 36-bit long word, an 18-bit half word, or a 9-bit byte lane. It holds one long word at a time and hands it out as one, two or four pieces. Each read enable pulse on the port consumes one piece. A new long word is taken from the FIFO only after the last piece of the current one has been consumed.

The piece order is chosen while reset is asserted. In big-first order the most significant piece leaves first. In little-first order the least significant piece leaves first. The width and order selects are sampled only while reset is low and are ignored afterwards.

The FIFO side uses a valid/ready handshake. The port side has a read enable input, a data output and an empty indication. The empty indication is high when no piece is waiting, meaning the holding register is empty. This covers both the case where the FIFO has nothing and the case where the last piece has just been consumed.

Top module: `busmatch_rd_conv`

## Requirements
- R1: After reset, `out_empty` is 1, `out_data` is 0 and, with `src_valid` low, `src_ready` is 1.
- R2: With `cfg_narrow`=0 (long mode), each long word leaves as one piece, and `out_data` equals the stored 36-bit word.
- R3: With `cfg_narrow`=1 and `cfg_byte`=0 (half mode), each word leaves as two 18-bit pieces on `out_data[17:0]`, with `out_data[35:18]`=0. The two pieces are word bits [35:18] and [17:0].
- R4: With `cfg_narrow`=1 and `cfg_byte`=1 (byte mode), each word leaves as four 9-bit pieces on `out_data[8:0]`, with the upper bits 0. Piece lane n is word bits [9n+8:9n].
- R5: With `cfg_big_first`=1 during reset, pieces leave from the most significant to the least significant: lane 3,2,1,0 or half 1,0.
- R6: With `cfg_big_first`=0 during reset, pieces leave from the least significant to the most significant: lane 0,1,2,3 or half 0,1.
- R7: The three configuration inputs are sampled only while `rst_n` is low. Changes to them after reset have no effect on width or order.
- R8: While a piece other than the last is pending, `src_ready` is 0 and the held word does not change. `src_ready` is 1 in the cycle where the last piece is read with `rd_en`=1.
- R9: While `out_empty` is 1, `rd_en` has no effect: no piece is lost and the first piece of the next word is shown intact.
- R10: When the last piece is read while `src_valid` is 1, the next word is loaded on the same edge, so `out_empty` stays 0 with no gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is sampled while low |
| cfg_big_first | input | 1 | 1: most significant piece first; 0: least significant first |
| cfg_narrow | input | 1 | 0: long-word width; 1: narrow width picked by `cfg_byte` |
| cfg_byte | input | 1 | With `cfg_narrow`=1: 1 selects byte width, 0 selects half width |
| src_data | input | 36 | Long word offered by the FIFO |
| src_valid | input | 1 | FIFO has a word available |
| src_ready | output | 1 | Converter takes the offered word on this edge |
| rd_en | input | 1 | Port read enable; consumes one piece per cycle |
| out_data | output | 36 | Current piece, right-aligned, unused upper bits zero |
| out_empty | output | 1 | No piece is pending |

## Verification
A word offered while the holding register is empty is loaded on the next rising edge. Its first piece appears on `out_data` one cycle after being offered. Each read enable advances to the next piece on the following edge. `src_ready` is a combinational function of `rd_en` and the holding state, so the bench checks it one time unit after driving `rd_en`. All other outputs are checked at the falling edge after the rising edge that should have changed them. The bench sweeps all six width and order combinations. It scrambles the configuration inputs after reset, inserts idle cycles between reads, and pulses `rd_en` while the converter is empty.

// File: rtl/bm_pkg.sv
// Package: shared mode type and the decode of the two width selects.
// Assumes the width selects are static once reset is released.
package bm_pkg;

    typedef enum logic [1:0] {
        MODE_LONG = 2'd0,
        MODE_HALF = 2'd1,
        MODE_LANE = 2'd2
    } bm_mode_e;

    // Turns the narrow/byte select pair into a port width mode.
    function automatic bm_mode_e decode_mode(input logic narrow, input logic bytew);
        if (!narrow) begin
            return MODE_LONG;
        end
        return bytew ? MODE_LANE : MODE_HALF;
    endfunction

endpackage

// File: rtl/bm_cfg_latch.sv
// Module: captures width mode and piece order while reset is low.
// Assumes rst_n is held low for at least one clock edge.
module bm_cfg_latch
    import bm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     big_in,
    input  logic     narrow_in,
    input  logic     byte_in,
    output bm_mode_e mode_o,
    output logic     big_o
);

    // Sample the configuration inputs only during reset; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= decode_mode(narrow_in, byte_in);
            big_o  <= big_in;
        end
    end

endmodule

// File: rtl/bm_hold_ctr.sv
// Module: one-word holding register with a piece counter and the FIFO handshake.
// Assumes LANES is a power of two of at least 2.
module bm_hold_ctr
    import bm_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int WORD_W = LANE_W * LANES,
    localparam int IDX_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bm_mode_e          mode,
    input  logic [WORD_W-1:0] src_data,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic              rd_en,
    output logic [WORD_W-1:0] hold_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic              hold_vld
);

    logic [IDX_W-1:0] last_idx;
    logic             is_last;
    logic             advance;
    logic             take;

    // Index of the final piece for the latched width mode.
    always_comb begin
        case (mode)
            MODE_HALF: last_idx = IDX_W'(1);
            MODE_LANE: last_idx = IDX_W'(LANES - 1);
            default:   last_idx = '0;
        endcase
    end

    // Handshake terms: accept a word only when empty or draining the final piece.
    always_comb begin
        is_last   = (idx_q == last_idx);
        advance   = rd_en && hold_vld;
        src_ready = !hold_vld || (advance && is_last);
        take      = src_valid && src_ready;
    end

    // Load, step through pieces, and release the word after its last piece.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= '0;
            idx_q    <= '0;
            hold_vld <= 1'b0;
        end else if (take) begin
            hold_q   <= src_data;
            idx_q    <= '0;
            hold_vld <= 1'b1;
        end else if (advance && is_last) begin
            idx_q    <= '0;
            hold_vld <= 1'b0;
        end else if (advance) begin
            idx_q    <= idx_q + IDX_W'(1);
        end
    end

    // R8: a word with pieces left is neither replaced nor requested.
    p_no_fetch_midword_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld && !is_last) |-> !src_ready);

    // R8: without a read the held word and position stay put.
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld && !rd_en) |=> ($stable(hold_q) && $stable(idx_q) && hold_vld));

    // R9: a read while empty with nothing offered leaves the converter empty.
    p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_vld && !src_valid) |=> (!hold_vld && idx_q == '0));

    // R10: draining the last piece with a word on offer keeps the port occupied.
    p_no_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && is_last && src_valid) |=> (hold_vld && idx_q == '0));

endmodule

// File: rtl/bm_lane_mux.sv
// Module: selects the current piece from the held word by mode, order and index.
// Assumes idx never exceeds the last piece index of the mode; output is zero when empty.
module bm_lane_mux
    import bm_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int WORD_W = LANE_W * LANES,
    localparam int HALF_W = WORD_W / 2,
    localparam int IDX_W  = $clog2(LANES)
) (
    input  bm_mode_e          mode,
    input  logic              big,
    input  logic [WORD_W-1:0] hold,
    input  logic [IDX_W-1:0]  idx,
    input  logic              vld,
    output logic [WORD_W-1:0] out
);

    logic [LANE_W-1:0] lane [LANES];
    logic [HALF_W-1:0] half [2];
    logic              hsel;
    logic [IDX_W-1:0]  lsel;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = hold[g*LANE_W +: LANE_W];
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign half[h] = hold[h*HALF_W +: HALF_W];
    end

    // Map the piece index to a physical half or lane according to the order.
    always_comb begin
        hsel = big ? ~idx[0] : idx[0];
        lsel = big ? (IDX_W'(LANES - 1) - idx) : idx;
    end

    // Right-align the chosen piece and zero everything else.
    always_comb begin
        out = '0;
        if (vld) begin
            case (mode)
                MODE_HALF: out[HALF_W-1:0] = half[hsel];
                MODE_LANE: out[LANE_W-1:0] = lane[lsel];
                default:   out             = hold;
            endcase
        end
    end

endmodule

// File: rtl/busmatch_rd_conv.sv
// Module: read-side bus-matching converter; splits FIFO long words for a narrower port.
// Assumes configuration inputs are meaningful while rst_n is low and src_data
// is stable while src_valid is high and not yet accepted.
module busmatch_rd_conv
    import bm_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int WORD_W = LANE_W * LANES,
    localparam int IDX_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_big_first,
    input  logic              cfg_narrow,
    input  logic              cfg_byte,
    input  logic [WORD_W-1:0] src_data,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic              rd_en,
    output logic [WORD_W-1:0] out_data,
    output logic              out_empty
);

    bm_mode_e          mode_q;
    logic              big_q;
    logic [WORD_W-1:0] hold_q;
    logic [IDX_W-1:0]  idx_q;
    logic              hold_vld;

    bm_cfg_latch u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .big_in    (cfg_big_first),
        .narrow_in (cfg_narrow),
        .byte_in   (cfg_byte),
        .mode_o    (mode_q),
        .big_o     (big_q)
    );

    bm_hold_ctr #(.LANE_W(LANE_W), .LANES(LANES)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .src_data  (src_data),
        .src_valid (src_valid),
        .src_ready (src_ready),
        .rd_en     (rd_en),
        .hold_q    (hold_q),
        .idx_q     (idx_q),
        .hold_vld  (hold_vld)
    );

    bm_lane_mux #(.LANE_W(LANE_W), .LANES(LANES)) u_mux (
        .mode (mode_q),
        .big  (big_q),
        .hold (hold_q),
        .idx  (idx_q),
        .vld  (hold_vld),
        .out  (out_data)
    );

    // Empty covers both an idle FIFO and a fully drained word.
    assign out_empty = !hold_vld;

    // R7: configuration is frozen once reset has been released.
    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($stable(mode_q) && $stable(big_q)));

    // R1: nothing pending means the port shows zero.
    p_empty_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_empty |-> (out_data == '0));

endmodule

// File: tb/sim_busmatch_rd_conv.sv
// Bench: sweeps all width/order combinations, computing each expected piece arithmetically.
module sim_busmatch_rd_conv;

    localparam int NW = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_big_first = 1'b0;
    logic        cfg_narrow = 1'b0;
    logic        cfg_byte = 1'b0;
    logic [35:0] src_data;
    logic        src_valid;
    logic        src_ready;
    logic        rd_en = 1'b0;
    logic [35:0] out_data;
    logic        out_empty;

    int n_chk  = 0;
    int n_fail = 0;
    int avail  = 0;
    int head   = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [35:0] word_of(input int n);
        logic [35:0] w;
        w = 36'h1_2345_6789 + 36'(n) * 36'h0_9E37_79B9;
        return w ^ {4'(n), 32'h0};
    endfunction

    assign src_valid = rst_n && (head < avail);
    assign src_data  = src_valid ? word_of(head) : 36'h0;

    // FIFO model: pop the head on an accepted handshake.
    always @(posedge clk) begin
        if (!rst_n) head <= 0;
        else if (src_valid && src_ready) head <= head + 1;
    end

    busmatch_rd_conv u0 (
        .clk(clk), .rst_n(rst_n), .cfg_big_first(cfg_big_first),
        .cfg_narrow(cfg_narrow), .cfg_byte(cfg_byte), .src_data(src_data),
        .src_valid(src_valid), .src_ready(src_ready), .rd_en(rd_en),
        .out_data(out_data), .out_empty(out_empty)
    );

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int pieces_of(input bit narrow, input bit bytew);
        if (!narrow) return 1;
        return bytew ? 4 : 2;
    endfunction

    function automatic logic [35:0] exp_piece(input logic [35:0] w, input bit narrow,
                                              input bit bytew, input bit big, input int k);
        int sel;
        if (!narrow) return w;
        if (!bytew) begin
            sel = big ? 1 - k : k;
            return {18'h0, w[sel*18 +: 18]};
        end
        sel = big ? 3 - k : k;
        return {27'h0, w[sel*9 +: 9]};
    endfunction

    task automatic run_cfg(input bit narrow, input bit bytew, input bit big);
        int np;
        string rq;
        np = pieces_of(narrow, bytew);
        rq = !narrow ? "R2" : (bytew ? "R4" : "R3");
        @(negedge clk);
        rst_n = 1'b0; avail = 0; rd_en = 1'b0;
        cfg_narrow = narrow; cfg_byte = bytew; cfg_big_first = big;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7: scramble the selects after reset; behaviour must not follow them.
        cfg_narrow = ~narrow; cfg_byte = ~bytew; cfg_big_first = ~big;
        #1;
        check("R1 empty after reset", 36'(out_empty), 36'd1);
        check("R1 data after reset", out_data, 36'h0);
        check("R1 ready after reset", 36'(src_ready), 36'd1);
        // R9: reads while empty do nothing.
        rd_en = 1'b1;
        repeat (3) @(negedge clk);
        rd_en = 1'b0; #1;
        check("R9 empty after idle reads", 36'(out_empty), 36'd1);
        avail = NW;
        @(negedge clk);
        for (int w = 0; w < NW; w++) begin
            for (int k = 0; k < np; k++) begin
                rd_en = 1'b0; #1;
                check(w == 0 ? "R9 first piece present" : "R10 no gap", 36'(out_empty), 36'd0);
                check(big ? {rq, " R5 R7 piece"} : {rq, " R6 R7 piece"},
                      out_data, exp_piece(word_of(w), narrow, bytew, big, k));
                check("R8 ready low while held", 36'(src_ready), 36'd0);
                if ((w + k) % 5 == 3) begin
                    @(negedge clk); #1;
                    check("R8 piece held without read", out_data,
                          exp_piece(word_of(w), narrow, bytew, big, k));
                end
                rd_en = 1'b1; #1;
                check("R8 ready only on last piece", 36'(src_ready), 36'(k == np - 1));
                @(negedge clk);
            end
        end
        rd_en = 1'b0; #1;
        check("R9 empty after drain", 36'(out_empty), 36'd1);
        check("R1 zero data when empty", out_data, 36'h0);
    endtask

    initial begin
        for (int b = 0; b < 2; b++) begin
            run_cfg(1'b0, 1'b0, bit'(b));
            run_cfg(1'b1, 1'b0, bit'(b));
            run_cfg(1'b1, 1'b1, bit'(b));
        end
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule